// File: doc/BRIEF.md
# ARINC 429 Serial Word Transmitter

This block turns four byte-wide writes from a host into one 32-bit serial word and sends it on an avionics data line. The host uses a small parallel port made of a data byte, an address bit that marks the first (label) byte, and an active-low write strobe. The block gathers the bytes and can replace bit 32 with an odd-parity bit. It keeps the finished word in a buffer register, so the host can load the next word while the current one is still being shifted out.

The transmitter sends one bit per period of its transmit clock, and a quiet gap of at least four bit periods follows every word. A one/zero pair of return-to-zero strobes carries each bit for the 429-style line. A plain level line and an active-low sync pulse carry the same bit sequence for the 561 format. A ready flag tells the host when the buffer can take a new word. The write strobe is synchronized into the transmit clock domain, so the host must hold `din` and `a0` steady for three transmit clock periods after `wr_n` rises.

Top module: `tx429_top`

## Requirements
- R1: Each word takes exactly 32 consecutive bit periods and is followed by a gap of at least 4 bit periods. Every bit of a word is sent, with no truncation.
- R2: Bit order on the line: bits 1 to 8 are the label byte, most-significant bit first. Bits 9 to 16, 17 to 24 and 25 to 32 are the second, third and fourth bytes, each least-significant bit first.
- R3: A write with `a0`=1 stores the label and restarts byte counting, even in the middle of a word. The next three writes with `a0`=0 complete the word. A write with `a0`=0 that arrives while no label is pending is ignored.
- R4: `ready` is 1 while the buffer is empty and 0 from the capture of the fourth byte until the word moves into the shift register. Writes made while `ready` is 0 are ignored.
- R5: A buffered word moves into the shift register during the 4th gap period of the word being sent, so back-to-back words are separated by exactly 4 gap periods. If the transmitter is already idle, the move happens in the cycle after capture. `ready` returns to 1 after the move.
- R6: With `parity_en`=1 at fourth-byte capture, bit 32 is chosen so that the 32-bit word has an odd number of ones. With `parity_en`=0, bit 32 is bit 7 of the fourth byte.
- R7: `bit_one` is high, in the clock-high half of a bit period only, for a 1 bit. `bit_zero` is high in the same way for a 0 bit. Both are low during the gap, and they are never high together.
- R8: `sync561_n` is low only in the clock-low half of the 8th bit period of each word.
- R9: `data561` carries each word's bit sequence as an NRZ level for whole bit periods and is 0 during the gap.
- R10: After reset, `ready` is 1, all line outputs are idle (strobes 0, `data561` 0, `sync561_n` 1), and a continuous gap is sent until the first complete word is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, one bit per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_n | input | 1 | Active-low write strobe; byte taken on its rising edge |
| a0 | input | 1 | 1 marks the label (first) byte |
| din | input | 8 | Byte written by the host |
| parity_en | input | 1 | 1 makes bit 32 an odd-parity bit |
| ready | output | 1 | Buffer empty, a new word may be written |
| bit_one | output | 1 | Return-to-zero strobe for a 1 bit |
| bit_zero | output | 1 | Return-to-zero strobe for a 0 bit |
| data561 | output | 1 | NRZ serial data, 561 format |
| sync561_n | output | 1 | Active-low sync pulse in bit 8 |

## Verification
Random bytes with random parity selection are sent back to back, which checks bit order, parity and that exactly four gap periods separate queued words. Directed words use all-zero and all-one bytes with parity on and off, and a fourth byte with bit 7 set and clear, which separates a parity-generated bit 32 from a passed-through one. A word sent after an idle period shows the immediate-load path. This is told apart from the queued path by gap length. A label rewritten mid-word, orphan `a0`=0 writes, and a stray label written while the buffer is full each leave a wrong word on the line if they are not handled as specified.

// File: rtl/tx429_pkg.sv
package tx429_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned NBYTES    = 4;
  localparam int unsigned WORD_W    = BYTE_W * NBYTES;
  localparam int unsigned GAP_W     = 4;
  localparam int unsigned SLOTS     = WORD_W + GAP_W;
  localparam int unsigned SLOT_W    = $clog2(SLOTS);
  localparam int unsigned SYNC_SLOT = 7;  // zero-based slot of bit 8
  localparam int unsigned CNT_W     = $clog2(NBYTES);
endpackage

// File: rtl/tx429_wrsync.sv
module tx429_wrsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_n,
  output logic wr_pulse
);
  localparam int unsigned DEPTH = STAGES + 1;

  logic [DEPTH-1:0] pipe_q;
  logic [DEPTH-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[DEPTH-2:0], wr_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {DEPTH{1'b1}};
    else        pipe_q <= pipe_d;
  end

  // rising edge of the synchronized strobe
  assign wr_pulse = pipe_q[DEPTH-2] & ~pipe_q[DEPTH-1];
endmodule

// File: rtl/tx429_wordbuf.sv
module tx429_wordbuf
  import tx429_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_pulse,
  input  logic              a0,
  input  logic [BYTE_W-1:0] din,
  input  logic              parity_en,
  input  logic              take,
  output logic              full,
  output logic [WORD_W-1:0] word
);
  logic [BYTE_W-1:0] held_q [NBYTES-1];
  logic [BYTE_W-1:0] held_d [NBYTES-1];
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              full_q, full_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic [WORD_W-1:0] asm_w;
  logic              accept;

  // word in line order: index 0 is the first bit sent
  always_comb begin
    for (int i = 0; i < BYTE_W; i++) asm_w[i] = held_q[0][BYTE_W-1-i];
    for (int k = 1; k < NBYTES-1; k++)
      for (int j = 0; j < BYTE_W; j++) asm_w[k*BYTE_W+j] = held_q[k][j];
    for (int j = 0; j < BYTE_W; j++) asm_w[(NBYTES-1)*BYTE_W+j] = din[j];
    if (parity_en) asm_w[WORD_W-1] = ~(^asm_w[WORD_W-2:0]);
  end

  assign accept = wr_pulse & ~full_q;

  always_comb begin
    held_d = held_q;
    cnt_d  = cnt_q;
    full_d = full_q;
    word_d = word_q;
    if (take) full_d = 1'b0;
    if (accept) begin
      if (a0) begin
        held_d[0] = din;
        cnt_d     = CNT_W'(1);
      end else if (cnt_q != '0) begin
        if (cnt_q == CNT_W'(NBYTES-1)) begin
          word_d = asm_w;
          full_d = 1'b1;
          cnt_d  = '0;
        end else begin
          held_d[cnt_q] = din;
          cnt_d         = cnt_q + CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NBYTES-1; k++) held_q[k] <= '0;
      cnt_q  <= '0;
      full_q <= 1'b0;
      word_q <= '0;
    end else begin
      held_q <= held_d;
      cnt_q  <= cnt_d;
      full_q <= full_d;
      word_q <= word_d;
    end
  end

  assign full = full_q;
  assign word = word_q;
endmodule

// File: rtl/tx429_serializer.sv
module tx429_serializer
  import tx429_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              full,
  input  logic [WORD_W-1:0] word,
  output logic              take,
  output logic              data_phase,
  output logic              cur_bit,
  output logic              bit8
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS-1);
  localparam logic [SLOT_W-1:0] DATA_END  = SLOT_W'(WORD_W);

  logic              busy_q, busy_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [WORD_W-1:0] sh_q, sh_d;

  assign take = full & (~busy_q | (slot_q == LAST_SLOT));

  always_comb begin
    busy_d = busy_q;
    slot_d = slot_q;
    sh_d   = sh_q;
    if (take) begin
      busy_d = 1'b1;
      slot_d = '0;
      sh_d   = word;
    end else if (busy_q) begin
      sh_d = {1'b0, sh_q[WORD_W-1:1]};
      if (slot_q == LAST_SLOT) begin
        busy_d = 1'b0;
        slot_d = '0;
      end else begin
        slot_d = slot_q + SLOT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      slot_q <= '0;
      sh_q   <= '0;
    end else begin
      busy_q <= busy_d;
      slot_q <= slot_d;
      sh_q   <= sh_d;
    end
  end

  assign data_phase = busy_q & (slot_q < DATA_END);
  assign cur_bit    = sh_q[0];
  assign bit8       = busy_q & (slot_q == SLOT_W'(SYNC_SLOT));
endmodule

// File: rtl/tx429_top.sv
module tx429_top
  import tx429_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic              a0,
  input  logic [BYTE_W-1:0] din,
  input  logic              parity_en,
  output logic              ready,
  output logic              bit_one,
  output logic              bit_zero,
  output logic              data561,
  output logic              sync561_n
);
  logic [1:0]        rst_q;
  logic              srst_n;
  logic              wr_pulse;
  logic              take;
  logic              full;
  logic [WORD_W-1:0] word;
  logic              data_phase;
  logic              cur_bit;
  logic              bit8;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign srst_n = rst_q[1];

  tx429_wrsync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(srst_n), .wr_n(wr_n), .wr_pulse(wr_pulse)
  );

  tx429_wordbuf u_buf (
    .clk(clk), .rst_n(srst_n), .wr_pulse(wr_pulse), .a0(a0), .din(din),
    .parity_en(parity_en), .take(take), .full(full), .word(word)
  );

  tx429_serializer u_ser (
    .clk(clk), .rst_n(srst_n), .full(full), .word(word), .take(take),
    .data_phase(data_phase), .cur_bit(cur_bit), .bit8(bit8)
  );

  assign ready     = ~full;
  assign bit_one   = clk & data_phase & cur_bit;
  assign bit_zero  = clk & data_phase & ~cur_bit;
  assign data561   = data_phase & cur_bit;
  assign sync561_n = ~(bit8 & ~clk);
endmodule

// File: rtl/tx429_chk.sv
module tx429_chk (
  input logic clk,
  input logic rst_n,
  input logic take,
  input logic full,
  input logic data_phase,
  input logic bit8,
  input logic bit_one,
  input logic bit_zero
);
  AST_LOAD_STARTS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> data_phase);                                   // R5
  AST_LOAD_FREES_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !full);                                        // R5
  AST_NO_CUT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    data_phase |-> !take);                                  // R1
  AST_BUF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !take) |=> full);                              // R4
  AST_SYNC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bit8 |=> (!bit8 && data_phase));                        // R8

  always_comb begin
    if (rst_n) begin
      AST_STROBE_EXCL: assert (!(bit_one && bit_zero));     // R7
    end
  end
endmodule

bind tx429_top tx429_chk u_chk (
  .clk(clk), .rst_n(srst_n), .take(take), .full(full),
  .data_phase(data_phase), .bit8(bit8), .bit_one(bit_one), .bit_zero(bit_zero)
);

// File: tb/sim_tx429_top.sv
`timescale 1ns/1ps
module sim_tx429_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_n = 1'b1;
  logic a0 = 1'b0;
  logic [7:0] din = 8'h00;
  logic parity_en = 1'b0;
  logic ready, bit_one, bit_zero, data561, sync561_n;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  bit mon_on = 1'b0;

  logic [31:0] exp_q[$];
  bit          tight_q[$];

  always #10 clk = ~clk;

  tx429_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .a0(a0), .din(din),
    .parity_en(parity_en), .ready(ready), .bit_one(bit_one),
    .bit_zero(bit_zero), .data561(data561), .sync561_n(sync561_n)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // expected line-order word, index 0 first on the line
  function automatic logic [31:0] line_word(input logic [7:0] b0, b1, b2, b3, input bit pen);
    logic [31:0] w;
    for (int i = 0; i < 8; i++) w[i] = b0[7-i];
    for (int j = 0; j < 8; j++) begin
      w[8+j]  = b1[j];
      w[16+j] = b2[j];
      w[24+j] = b3[j];
    end
    if (pen) w[31] = ~(^w[30:0]);
    return w;
  endfunction

  task automatic wr_byte(input bit addr, input logic [7:0] d);
    @(negedge clk);
    a0 = addr; din = d; wr_n = 1'b0;
    repeat (2) @(negedge clk);
    wr_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_word(input logic [7:0] b0, b1, b2, b3, input bit pen);
    bit waited = 1'b0;
    @(negedge clk);
    while (!ready) begin waited = 1'b1; @(negedge clk); end
    parity_en = pen;
    exp_q.push_back(line_word(b0, b1, b2, b3, pen));
    tight_q.push_back(waited);
    wr_byte(1'b1, b0); wr_byte(1'b0, b1); wr_byte(1'b0, b2); wr_byte(1'b0, b3);
  endtask

  // line monitor
  int idx = 0;
  int gap = 1000;
  int rz_err = 0, d_err = 0, sync_lows = 0, sync_at = 0;
  bit seen_word = 1'b0;
  logic [31:0] cur;
  logic [31:0] ew;
  bit tight;

  always begin
    @(posedge clk);
    #5;
    if (mon_on) begin
      if (!sync561_n) rz_err++;
      if (bit_one || bit_zero) begin
        if (bit_one && bit_zero) rz_err++;
        if (idx == 0) begin
          tight = (tight_q.size() != 0) ? tight_q[0] : 1'b0;
          if (seen_word) begin
            if (tight) check(gap == 4, "R5 queued gap", gap, 4);
            else       check(gap >= 4, "R1 gap length", gap, 4);
          end
          rz_err = 0; d_err = 0; sync_lows = 0; sync_at = 0;
        end
        if (data561 !== bit_one) d_err++;
        cur[idx] = bit_one;
        idx++;
      end else begin
        if (idx != 0) begin
          check(1'b0, "R1 word cut short", idx, 32);
          idx = 0;
        end
        if (data561 !== 1'b0) d_err++;
        gap++;
      end
    end
    #10;
    if (mon_on) begin
      if (bit_one || bit_zero) rz_err++;
      if (!sync561_n) begin sync_lows++; sync_at = idx; end
      if (idx == 32) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected word", cur, 0);
        end else begin
          ew = exp_q.pop_front();
          void'(tight_q.pop_front());
          check(cur == ew, "R2/R6 word content", cur, ew);
        end
        check(rz_err == 0, "R7 strobe shape", rz_err, 0);
        check(sync_lows == 1 && sync_at == 8, "R8 sync position", sync_at, 8);
        check(d_err == 0, "R9 561 data level", d_err, 0);
        idx = 0; gap = 0; seen_word = 1'b1;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r0, r1, r2, r3;
    void'($urandom(32'h2c5a));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R10 reset state, both halves of the clock
    check(ready === 1'b1, "R10 ready after reset", ready, 1);
    check({bit_one, bit_zero, data561} === 3'b000, "R10 idle line", {bit_one, bit_zero, data561}, 0);
    check(sync561_n === 1'b1, "R10 sync idle low half", sync561_n, 1);
    @(posedge clk); #5;
    check({bit_one, bit_zero, data561, sync561_n} === 4'b0001, "R10 idle high half",
          {bit_one, bit_zero, data561, sync561_n}, 1);
    repeat (40) @(negedge clk);
    check({bit_one, bit_zero} === 2'b00 && ready === 1'b1, "R10 continuous gap", {bit_one, bit_zero}, 0);
    mon_on = 1'b1;

    // directed parity corners, R6
    send_word(8'h00, 8'h00, 8'h00, 8'h00, 1'b1);
    send_word(8'hFF, 8'hFF, 8'hFF, 8'hFF, 1'b1);
    send_word(8'h81, 8'h3C, 8'h5A, 8'h80, 1'b0);
    send_word(8'h81, 8'h3C, 8'h5A, 8'h7F, 1'b0);

    // random back-to-back words, R1 R2 R5 R6
    for (int n = 0; n < 24; n++) begin
      r0 = 8'($urandom); r1 = 8'($urandom); r2 = 8'($urandom); r3 = 8'($urandom);
      send_word(r0, r1, r2, r3, 1'($urandom));
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (60) @(negedge clk);

    // idle-load path, then queued word: R4 ready low while full
    send_word(8'h12, 8'h34, 8'h56, 8'h78, 1'b0);
    send_word(8'h9A, 8'hBC, 8'hDE, 8'hF0, 1'b1);
    check(ready === 1'b0, "R4 ready low with word buffered", ready, 0);
    // stray label while full must be ignored (R4)
    wr_byte(1'b1, 8'hA5);
    while (!ready) @(negedge clk);
    // orphan low-address bytes: ignored (R3)
    wr_byte(1'b0, 8'h11); wr_byte(1'b0, 8'h22); wr_byte(1'b0, 8'h33);
    repeat (50) @(negedge clk);
    check(ready === 1'b1, "R3 orphan bytes not loaded", ready, 1);
    // label restart mid-word (R3)
    parity_en = 1'b0;
    wr_byte(1'b1, 8'hEE); wr_byte(1'b0, 8'hDD);
    exp_q.push_back(line_word(8'h6B, 8'h01, 8'h02, 8'h83, 1'b0));
    tight_q.push_back(1'b0);
    wr_byte(1'b1, 8'h6B); wr_byte(1'b0, 8'h01); wr_byte(1'b0, 8'h02); wr_byte(1'b0, 8'h83);
    while (exp_q.size() != 0) @(negedge clk);
    repeat (60) @(negedge clk);
    check(exp_q.size() == 0 && idx == 0, "R3 no extra words", idx, 0);
    check(ready === 1'b1, "R5 ready high after drain", ready, 1);

    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule